// File: doc/BRIEF.md
# Packed SIMD Lane Adder with Saturation

This block is a registered lane ALU for 32-bit data words. Each word is treated either as four independent 8-bit lanes or as two independent 16-bit lanes, and one operation is applied to every lane at once. The operations are add, subtract, halving add and halving subtract (the halving forms can round), absolute value, and three lane-wise comparisons. Lanes are read as signed or unsigned under a select input. Plain add and subtract either clamp to the lane limits or wrap to the lane width.

When `valid` is high on a rising clock edge, the block registers three things. It updates the result word. It sets the sticky overflow bit of a 32-bit control word. It rewrites the compare-condition field of that control word. A compare bitmask output and an optional form that writes the mask into the result word let the comparisons drive later lane selects.

Top module: `simd_lane_alu`

## Requirements
- R1: `lane_fmt`=0 splits a word into four 8-bit lanes and `lane_fmt`=1 splits it into two 16-bit lanes. Lane 0 is in the least significant bits, and results are repacked in the same lane order.
- R2: Opcode encoding is 0 add, 1 subtract, 2 halving add, 3 halving subtract, 4 absolute value, 5 compare equal, 6 compare less-than, 7 compare less-or-equal. All outputs change only on a clock edge with `valid` high, and they show the new values one cycle after that edge.
- R3: With `saturate`=1, an add or subtract lane result above the lane maximum becomes the maximum, and one below the minimum becomes the minimum. The limits are -2^(W-1)..2^(W-1)-1 when signed and 0..2^W-1 when unsigned.
- R4: With `saturate`=0, an add or subtract lane keeps the low W bits of the exact result. Overflow is still reported when any lane was out of range.
- R5: Add, subtract or absolute-value overflow in any lane sets control bit 20. The bit stays set until reset.
- R6: A halving lane result is the low W bits of (a op b + round) shifted arithmetically right by one, computed at full precision. Halving never sets the overflow bit.
- R7: Absolute value always reads lanes as signed. The most negative value gives the most positive value and sets overflow. Other negative lanes are negated, and non-negative lanes pass through.
- R8: A compare writes lane i's outcome into control bit 24+i and clears the rest of bits 27:24. It also drives the same four bits on `cmp_mask`, and it uses `is_signed` for ordering. Non-compare operations leave bits 27:24 and `cmp_mask` unchanged.
- R9: A compare with `cmp_gen`=1 writes `cmp_mask` zero-extended into the result word. A compare with `cmp_gen`=0 leaves the result word unchanged.
- R10: Reset sets result, control word and mask to zero. Control bits other than 20 and 27:24 never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Performs the operation on this edge |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| lane_fmt | input | 1 | 0: four 8-bit lanes, 1: two 16-bit lanes |
| is_signed | input | 1 | Lanes read as signed when 1 |
| saturate | input | 1 | Clamp add/subtract results when 1 |
| round | input | 1 | Adds one before halving |
| opcode | input | 3 | Operation select |
| cmp_gen | input | 1 | Compare also writes mask into result |
| result | output | 32 | Registered result word |
| ctrl | output | 32 | Control word: overflow bit 20, condition bits 27:24 |
| cmp_mask | output | 4 | Last compare per-lane outcome |

## Verification
The overflow bit is sticky, so once any operation sets it, no later operation can show whether that operation would have set it. Wrapped overflow, absolute value of the most negative lane and the no-overflow guarantee of halving would all be hidden. The stimulus therefore resets the block before each of those scenarios, so each one starts with the bit clear and its own effect on bit 20 can be observed. The condition field is seeded with all ones by a compare before arithmetic operations run, so a stray clear by those operations would show.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    localparam int WORD_W   = 32;
    localparam int OVF_BIT  = 20;
    localparam int COND_LSB = 24;
    localparam int COND_W   = 4;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_HADD = 3'd2,
        OP_HSUB = 3'd3,
        OP_ABS  = 3'd4,
        OP_CEQ  = 3'd5,
        OP_CLT  = 3'd6,
        OP_CLE  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] result;
        logic [WORD_W-1:0] ctrl;
        logic [COND_W-1:0] mask;
    } alu_state_t;

endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
    import simd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         sgn,
    input  logic         sat,
    input  logic         rnd,
    output logic [W-1:0] res,
    output logic         ovf,
    output logic         cc
);
    localparam int XW = W + 2;

    logic [XW-1:0] ea, eb, sa_ext, neg_a, full, half;
    logic [W-1:0]  hi_lim, lo_lim, smax, smin;
    logic          is_sub, fits, s_fit, u_fit;

    always_comb begin
        ea     = sgn ? {{2{a[W-1]}}, a} : {2'b00, a};
        eb     = sgn ? {{2{b[W-1]}}, b} : {2'b00, b};
        sa_ext = {{2{a[W-1]}}, a};
        neg_a  = '0 - sa_ext;
        is_sub = (op == OP_SUB) || (op == OP_HSUB);
        full   = is_sub ? (ea - eb) : (ea + eb);
        half   = full + {{(XW-1){1'b0}}, rnd};
        s_fit  = (full[W+1:W-1] == 3'b000) || (full[W+1:W-1] == 3'b111);
        u_fit  = (full[W+1:W] == 2'b00);
        fits   = sgn ? s_fit : u_fit;
        smax   = {1'b0, {(W-1){1'b1}}};
        smin   = {1'b1, {(W-1){1'b0}}};
        hi_lim = sgn ? smax : {W{1'b1}};
        lo_lim = sgn ? smin : {W{1'b0}};

        res = '0;
        ovf = 1'b0;
        cc  = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                ovf = !fits;
                if (!fits && sat)
                    res = full[W+1] ? lo_lim : hi_lim;
                else
                    res = full[W-1:0];
            end
            OP_HADD, OP_HSUB: res = half[W:1];
            OP_ABS: begin
                if (a == smin) begin
                    res = smax;
                    ovf = 1'b1;
                end else if (a[W-1]) begin
                    res = neg_a[W-1:0];
                end else begin
                    res = a;
                end
            end
            OP_CEQ: cc = (ea == eb);
            OP_CLT: cc = ($signed(ea) < $signed(eb));
            OP_CLE: cc = ($signed(ea) <= $signed(eb));
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/simd_fmt_merge.sv
module simd_fmt_merge
    import simd_alu_pkg::*;
#(
    parameter int NW = 8,
    parameter int NN = 4,
    parameter int WW = 16,
    parameter int WN = 2
) (
    input  logic [NN*NW-1:0] n_res,
    input  logic [NN-1:0]    n_ovf,
    input  logic [NN-1:0]    n_cc,
    input  logic [WN*WW-1:0] w_res,
    input  logic [WN-1:0]    w_ovf,
    input  logic [WN-1:0]    w_cc,
    input  logic             wide,
    output logic [WORD_W-1:0] word,
    output logic              ovf_any,
    output logic [COND_W-1:0] cc_bits
);
    always_comb begin
        if (wide) begin
            word    = w_res;
            ovf_any = |w_ovf;
            cc_bits = '0;
            cc_bits[WN-1:0] = w_cc;
        end else begin
            word    = n_res;
            ovf_any = |n_ovf;
            cc_bits = '0;
            cc_bits[NN-1:0] = n_cc;
        end
    end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_alu_pkg::*;
#(
    parameter int NARROW_W = WORD_W / 4,
    parameter int WIDE_W   = WORD_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              lane_fmt,
    input  logic              is_signed,
    input  logic              saturate,
    input  logic              round,
    input  logic [2:0]        opcode,
    input  logic              cmp_gen,
    output logic [WORD_W-1:0] result,
    output logic [WORD_W-1:0] ctrl,
    output logic [COND_W-1:0] cmp_mask
);
    localparam int N_NARROW = WORD_W / NARROW_W;
    localparam int N_WIDE   = WORD_W / WIDE_W;

    alu_op_e    op;
    alu_state_t st_d, st_q;

    logic [WORD_W-1:0]   n_res, w_res, word;
    logic [N_NARROW-1:0] n_ovf, n_cc;
    logic [N_WIDE-1:0]   w_ovf, w_cc;
    logic                ovf_any;
    logic [COND_W-1:0]   cc_bits;

    assign op = alu_op_e'(opcode);

    for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow
        simd_lane_unit #(.W(NARROW_W)) u_lane (
            .a   (op_a[i*NARROW_W +: NARROW_W]),
            .b   (op_b[i*NARROW_W +: NARROW_W]),
            .op  (op),
            .sgn (is_signed),
            .sat (saturate),
            .rnd (round),
            .res (n_res[i*NARROW_W +: NARROW_W]),
            .ovf (n_ovf[i]),
            .cc  (n_cc[i])
        );
    end

    for (genvar j = 0; j < N_WIDE; j++) begin : g_wide
        simd_lane_unit #(.W(WIDE_W)) u_lane (
            .a   (op_a[j*WIDE_W +: WIDE_W]),
            .b   (op_b[j*WIDE_W +: WIDE_W]),
            .op  (op),
            .sgn (is_signed),
            .sat (saturate),
            .rnd (round),
            .res (w_res[j*WIDE_W +: WIDE_W]),
            .ovf (w_ovf[j]),
            .cc  (w_cc[j])
        );
    end

    simd_fmt_merge #(
        .NW(NARROW_W), .NN(N_NARROW), .WW(WIDE_W), .WN(N_WIDE)
    ) u_merge (
        .n_res   (n_res),
        .n_ovf   (n_ovf),
        .n_cc    (n_cc),
        .w_res   (w_res),
        .w_ovf   (w_ovf),
        .w_cc    (w_cc),
        .wide    (lane_fmt),
        .word    (word),
        .ovf_any (ovf_any),
        .cc_bits (cc_bits)
    );

    always_comb begin
        st_d = st_q;
        if (valid) begin
            unique case (op)
                OP_ADD, OP_SUB, OP_HADD, OP_HSUB, OP_ABS: begin
                    st_d.result = word;
                    if (ovf_any)
                        st_d.ctrl[OVF_BIT] = 1'b1;
                end
                default: begin
                    st_d.ctrl[COND_LSB +: COND_W] = cc_bits;
                    st_d.mask = cc_bits;
                    if (cmp_gen)
                        st_d.result = {{(WORD_W-COND_W){1'b0}}, cc_bits};
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign result   = st_q.result;
    assign ctrl     = st_q.ctrl;
    assign cmp_mask = st_q.mask;
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid,
    input logic [2:0]  opcode,
    input logic        lane_fmt,
    input logic [31:0] result,
    input logic [31:0] ctrl,
    input logic [3:0]  cmp_mask
);
    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl[20] |=> ctrl[20]);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> ($stable(result) && $stable(ctrl) && $stable(cmp_mask)));

    // R10
    fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl & 32'hF0EF_FFFF) == 32'h0);

    // R8
    cond_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && opcode < 3'd5) |=> ($stable(ctrl[27:24]) && $stable(cmp_mask)));

    // R8
    wide_cond_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && opcode >= 3'd5 && lane_fmt) |=> (ctrl[27:26] == 2'b00 && cmp_mask[3:2] == 2'b00));

    // R7
    abs_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && opcode == 3'd4 && !lane_fmt) |=> (!result[7] && !result[15] && !result[23] && !result[31]));

    // R6
    half_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && (opcode == 3'd2 || opcode == 3'd3) && !ctrl[20]) |=> !ctrl[20]);
endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid    (valid),
    .opcode   (opcode),
    .lane_fmt (lane_fmt),
    .result   (result),
    .ctrl     (ctrl),
    .cmp_mask (cmp_mask)
);

// File: tb/simd_lane_alu_test.sv
`timescale 1ns/1ps
module simd_lane_alu_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        lane_fmt = 1'b0, is_signed = 1'b0, saturate = 1'b0, round = 1'b0, cmp_gen = 1'b0;
    logic [2:0]  opcode = '0;
    logic [31:0] result, ctrl;
    logic [3:0]  cmp_mask;

    int n_checks = 0;
    int n_fail = 0;
    logic [31:0] e_res, e_ctrl;
    logic [3:0]  e_mask;

    simd_lane_alu uut (
        .clk(clk), .rst(rst), .valid(valid), .op_a(op_a), .op_b(op_b),
        .lane_fmt(lane_fmt), .is_signed(is_signed), .saturate(saturate),
        .round(round), .opcode(opcode), .cmp_gen(cmp_gen),
        .result(result), .ctrl(ctrl), .cmp_mask(cmp_mask)
    );

    always #4 clk = ~clk;

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Lane reference from the requirement text, integer arithmetic.
    task automatic lane_ref(input int op, input int w, input bit sg, input bit st, input bit rd,
                            input int av, input int bv, output int rv, output bit ov, output bit cc);
        int x, y, m, r, lo, hi, sx;
        m  = (1 << w);
        x  = (sg && av >= m/2) ? av - m : av;
        y  = (sg && bv >= m/2) ? bv - m : bv;
        sx = (av >= m/2) ? av - m : av;
        lo = sg ? -(m/2) : 0;
        hi = sg ? (m/2 - 1) : (m - 1);
        ov = 0; cc = 0; r = 0;
        case (op)
            0, 1: begin
                r = (op == 0) ? x + y : x - y;
                if (r > hi || r < lo) begin
                    ov = 1;
                    if (st) r = (r > hi) ? hi : lo;
                end
            end
            2: r = (x + y + int'(rd)) >>> 1;
            3: r = (x - y + int'(rd)) >>> 1;
            4: begin
                if (sx == -(m/2)) begin r = m/2 - 1; ov = 1; end
                else r = (sx < 0) ? -sx : sx;
            end
            5: cc = (x == y);
            6: cc = (x < y);
            default: cc = (x <= y);
        endcase
        rv = r & (m - 1);
    endtask

    task automatic run_op(input string req, input int op, input bit fm, input bit sg, input bit st,
                          input bit rd, input bit gen, input logic [31:0] a, input logic [31:0] b);
        int w, n, rv;
        bit ov, cc, any_ov;
        logic [31:0] word;
        logic [3:0] bits;
        w = fm ? 16 : 8;
        n = 32 / w;
        word = '0; bits = '0; any_ov = 0;
        for (int i = 0; i < n; i++) begin
            lane_ref(op, w, sg, st, rd, int'((a >> (i*w)) & ((1 << w) - 1)),
                     int'((b >> (i*w)) & ((1 << w) - 1)), rv, ov, cc);
            word = word | (32'(rv) << (i*w));
            bits[i] = cc;
            any_ov = any_ov | ov;
        end
        if (op < 5) begin
            e_res = word;
            if (any_ov) e_ctrl[20] = 1'b1;
        end else begin
            e_ctrl[27:24] = bits;
            e_mask = bits;
            if (gen) e_res = {28'b0, bits};
        end
        @(negedge clk);
        valid = 1'b1; opcode = 3'(op); lane_fmt = fm; is_signed = sg;
        saturate = st; round = rd; cmp_gen = gen; op_a = a; op_b = b;
        @(negedge clk);
        valid = 1'b0;
        check(req, "result", result, e_res);
        check(req, "ctrl", ctrl, e_ctrl);
        check(req, "cmp_mask", {28'b0, cmp_mask}, {28'b0, e_mask});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        e_res = '0; e_ctrl = '0; e_mask = '0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R10", "reset result", result, 32'h0);
        check("R10", "reset ctrl", ctrl, 32'h0);
        check("R10", "reset mask", {28'b0, cmp_mask}, 32'h0);
    endtask

    task automatic t_wrap();
        do_reset();
        run_op("R4", 0, 1, 1, 0, 0, 0, 32'h0001_7FFF, 32'h0001_0001);
        check("R4", "wrapped lane0", result, 32'h0002_8000);
        check("R5", "ovf bit after wrap", 32'(ctrl[20]), 32'h1);
        run_op("R5", 0, 0, 0, 0, 0, 0, 32'h0101_0101, 32'h0101_0101);
        run_op("R1", 1, 0, 0, 0, 0, 0, 32'h4030_2010, 32'h0403_0201);
        check("R1", "lane order", result, 32'h3C2D_1E0F);
    endtask

    task automatic t_saturate();
        run_op("R3", 0, 0, 1, 1, 0, 0, 32'h7F80_0110, 32'h01FF_01F0);
        check("R3", "signed clamp", result, 32'h7F80_0200);
        run_op("R3", 0, 0, 0, 1, 0, 0, 32'hFF10_05F0, 32'h0120_0720);
        check("R3", "unsigned clamp hi", result, 32'hFF30_0CFF);
        run_op("R3", 1, 0, 0, 1, 0, 0, 32'h0010_0500, 32'h0108_0601);
        check("R3", "unsigned clamp lo", result, 32'h0008_0000);
        run_op("R3", 1, 1, 1, 1, 0, 0, 32'h8000_7FFF, 32'h0001_FFFF);
        check("R3", "signed 16 sub clamp", result, 32'h8000_7FFF);
    endtask

    task automatic t_halving();
        do_reset();
        run_op("R6", 2, 0, 1, 0, 0, 0, 32'h7F7F_0301, 32'h7F01_0100);
        run_op("R6", 2, 0, 1, 0, 1, 0, 32'h7F7F_0301, 32'h7F01_0100);
        run_op("R6", 3, 1, 1, 0, 1, 0, 32'h8000_0003, 32'h7FFF_0000);
        run_op("R6", 3, 0, 0, 0, 0, 0, 32'h0000_0402, 32'h0100_0201);
        check("R6", "no ovf from halving", 32'(ctrl[20]), 32'h0);
    endtask

    task automatic t_abs();
        do_reset();
        run_op("R7", 4, 0, 0, 0, 0, 0, 32'h7F01_FF85, 32'h0);
        check("R7", "no ovf without min lane", 32'(ctrl[20]), 32'h0);
        run_op("R7", 4, 1, 1, 0, 0, 0, 32'h8000_FFFE, 32'h0);
        check("R7", "min maps to max", result, 32'h7FFF_0002);
        check("R7", "ovf from abs", 32'(ctrl[20]), 32'h1);
    endtask

    task automatic t_compare();
        run_op("R8", 5, 0, 0, 0, 0, 0, 32'h1122_3344, 32'h1100_3300);
        run_op("R8", 6, 0, 1, 0, 0, 0, 32'hFF01_8000, 32'h0100_7F00);
        run_op("R8", 6, 0, 0, 0, 0, 0, 32'hFF01_8000, 32'h0100_7F00);
        run_op("R9", 7, 0, 0, 0, 0, 1, 32'h0505_0506, 32'h0505_0405);
        check("R9", "mask in result", result, 32'h0000_000C);
        run_op("R8", 5, 0, 0, 0, 0, 0, 32'h0, 32'h0);
        run_op("R8", 0, 0, 0, 1, 0, 0, 32'h0102_0304, 32'h1);
        check("R8", "cond kept by add", 32'(ctrl[27:24]), 32'hF);
        run_op("R8", 7, 1, 1, 0, 0, 1, 32'h0000_FFFF, 32'h0000_0000);
        check("R8", "wide cond bits", 32'(ctrl[27:24]), 32'h3);
    endtask

    task automatic t_hold();
        @(negedge clk);
        valid = 1'b0; opcode = 3'd0; op_a = 32'h7F7F_7F7F; op_b = 32'h7F7F_7F7F;
        saturate = 1'b0; is_signed = 1'b1; lane_fmt = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R2", "result held", result, e_res);
        check("R2", "ctrl held", ctrl, e_ctrl);
        check("R2", "mask held", {28'b0, cmp_mask}, {28'b0, e_mask});
    endtask

    initial begin
        e_res = '0; e_ctrl = '0; e_mask = '0;
        t_reset();
        t_wrap();
        t_saturate();
        t_halving();
        t_abs();
        t_compare();
        do_reset();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule